// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block sits on the controller side of an SDRAM interface. Its only job is to keep the array contents valid. An interval timer records how many auto-refresh commands are owed. The sequencer asks the main command scheduler for the bus and waits until it holds a grant and both banks report idle. It then issues the owed refreshes, with at least one row-cycle time between each command and the next.

Refresh can be spread out, with one command per short interval, or grouped as a burst, with a whole batch owed once per long retention window. A low-power request puts the device into self refresh, holds it there, and brings it back out. On the way out it allows one row-cycle time of NOPs. In burst mode it then owes a full batch of refreshes at once.

All cycle counts come from picosecond parameters at elaboration, rounded up to whole clocks. There is no data path, so every pin is a plain level signal. The scheduler handshake is a held request answered by a level grant.

Top module: `sdram_rfsh_seq`

## Requirements
- R1: While reset is held, the outputs are cke=1, cs_n=1, ref_req=0 and lp_ack=0.
- R2: In spread mode (burst_mode=0), one refresh becomes owed every REFI_CYC = ceil(REFI_PS/CLK_PS) cycles. With nothing owed before, ref_req first rises REFI_CYC cycles after reset is released.
- R3: An auto refresh drives cs_n=0, ras_n=0, cas_n=0, we_n=1 with cke=1. It appears on the pins one cycle after a clock edge at which refresh is owed, ref_gnt=1, banks_idle=1 and cke was already high. If either ref_gnt or banks_idle is low, no refresh is issued.
- R4: Any two commands (cs_n low) are at least TRC_CYC = ceil(TRC_PS/CLK_PS) cycles apart. When several refreshes are owed and the grant is held, they come out exactly TRC_CYC cycles apart.
- R5: ref_req stays high while a refresh is owed, even when the grant is withheld. It also stays high through the NOP wait after each refresh. It falls once nothing is owed and the wait has ended.
- R6: Refreshes that fall due while the grant is withheld are all issued later. The owed count saturates at OWED_MAX.
- R7: In burst mode (burst_mode=1), BURST_LEN refreshes become owed every ceil(BURST_WIN_PS/CLK_PS) cycles.
- R8: If lp_req is high, nothing is owed, and ref_gnt and banks_idle are high, self refresh is entered with cs_n=0, ras_n=0, cas_n=0, we_n=1 and cke=0. lp_ack is high in that same cycle.
- R9: While in self refresh, cke stays 0 and cs_n stays 1. ref_gnt and banks_idle have no effect, and no refresh becomes owed.
- R10: When lp_req falls, cke returns to 1 and lp_ack falls on the next edge. The first later command is TRC_CYC+1 cycles after cke rises, and ref_req falls once that wait ends with nothing owed.
- R11: On leaving self refresh in burst mode, exactly BURST_LEN refreshes become owed. In spread mode, none are owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode | input | 1 | 1 selects batched refresh, 0 spread refresh |
| banks_idle | input | 1 | Both banks are precharged and idle |
| ref_gnt | input | 1 | Scheduler has handed the command bus to this block |
| ref_req | output | 1 | This block needs or holds the command bus |
| lp_req | input | 1 | Request to enter (high) or leave (low) self refresh |
| lp_ack | output | 1 | Device is in self refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |

## Verification
The bench withholds the grant across many intervals and then grants. A design that drops deferred refreshes, or does not saturate the owed count, issues the wrong number of commands in that window. Owed refreshes issued back to back must be spaced exactly by the rounded row-cycle count, so an off-by-one in the wait counter or in the rounding shows up as a gap that is too short or too long. During self refresh the bench toggles the grant and idle inputs, and it measures the delay from cke rising to the first refresh. A sequencer that still reacts to the grant, leaves self refresh too early, or skips or always performs the batch after exit is caught there.

// File: rtl/sdram_rfsh_pkg.sv
package sdram_rfsh_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_cmd_t;

  localparam pin_cmd_t PIN_NOP  = pin_cmd_t'(4'b1111);
  // refresh and self-refresh entry share this pattern; cke tells them apart
  localparam pin_cmd_t PIN_RFSH = pin_cmd_t'(4'b0001);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RWAIT,
    ST_SELF,
    ST_XWAIT
  } seq_st_e;

  function automatic longint unsigned ps_to_cycles(input longint unsigned span_ps,
                                                   input longint unsigned clk_ps);
    return (span_ps + clk_ps - 64'd1) / clk_ps;
  endfunction

endpackage

// File: rtl/sdram_rfsh_timer.sv
module sdram_rfsh_timer #(
  parameter int unsigned PER_DIST  = 3900,
  parameter int unsigned PER_BURST = 8000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_sel,
  input  logic hold,
  output logic tick
);
  localparam int unsigned PER_MAX = (PER_BURST > PER_DIST) ? PER_BURST : PER_DIST;
  localparam int CW = $clog2(PER_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim  = burst_sel ? CW'(PER_BURST - 1) : CW'(PER_DIST - 1);
  assign tick = !hold && (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (hold || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdram_rfsh_debt.sv
module sdram_rfsh_debt #(
  parameter int unsigned OWED_MAX  = 4096,
  parameter int unsigned BURST_LEN = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic burst_sel,
  input  logic take,
  input  logic load_burst,
  input  logic clear,
  output logic owed_nz
);
  localparam int DW = $clog2(OWED_MAX + 1);
  localparam int unsigned LOAD_V = (BURST_LEN < OWED_MAX) ? BURST_LEN : OWED_MAX;

  logic [DW-1:0] owed_q;
  logic [DW:0]   add_v;
  logic [DW:0]   sum;

  always_comb begin
    add_v = '0;
    if (tick) add_v = burst_sel ? (DW+1)'(BURST_LEN) : (DW+1)'(1);
    sum = {1'b0, owed_q} + add_v - ((take && owed_q != '0) ? (DW+1)'(1) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       owed_q <= '0;
    else if (clear)                   owed_q <= '0;
    else if (load_burst)              owed_q <= DW'(LOAD_V);
    else if (sum > (DW+1)'(OWED_MAX)) owed_q <= DW'(OWED_MAX);
    else                              owed_q <= sum[DW-1:0];
  end

  assign owed_nz = (owed_q != '0);
endmodule

// File: rtl/sdram_rfsh_fsm.sv
module sdram_rfsh_fsm
  import sdram_rfsh_pkg::*;
#(
  parameter int unsigned TRC_CYC = 15
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     owed_nz,
  input  logic     ref_gnt,
  input  logic     banks_idle,
  input  logic     lp_req,
  input  logic     burst_sel,
  output pin_cmd_t cmd_o,
  output logic     cke_o,
  output logic     ref_req,
  output logic     lp_ack,
  output logic     take,
  output logic     load_burst,
  output logic     clear,
  output logic     timer_hold
);
  localparam int TW = $clog2(TRC_CYC + 2);
  localparam int unsigned RW_LOAD = (TRC_CYC > 1) ? TRC_CYC - 1 : 1;

  seq_st_e  st_q;
  logic [TW-1:0] wcnt_q;
  pin_cmd_t cmd_q;
  logic     cke_q;
  logic     wait_done;

  assign wait_done  = (wcnt_q == TW'(1));
  assign take       = (st_q == ST_IDLE) && cke_q && owed_nz && ref_gnt && banks_idle;
  assign clear      = (st_q == ST_IDLE) && cke_q && !owed_nz && lp_req && ref_gnt && banks_idle;
  assign load_burst = (st_q == ST_XWAIT) && wait_done && burst_sel;
  assign timer_hold = (st_q == ST_SELF) || (st_q == ST_XWAIT);
  assign ref_req    = (st_q != ST_IDLE) || owed_nz || lp_req;
  assign lp_ack     = (st_q == ST_SELF);
  assign cmd_o      = cmd_q;
  assign cke_o      = cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      cmd_q  <= PIN_NOP;
      cke_q  <= 1'b1;
    end else begin
      cmd_q <= PIN_NOP;
      unique case (st_q)
        ST_IDLE: begin
          if (take) begin
            cmd_q  <= PIN_RFSH;
            wcnt_q <= TW'(RW_LOAD);
            st_q   <= ST_RWAIT;
          end else if (clear) begin
            cmd_q <= PIN_RFSH;
            cke_q <= 1'b0;
            st_q  <= ST_SELF;
          end
        end
        ST_SELF: begin
          if (!lp_req) begin
            cke_q  <= 1'b1;
            wcnt_q <= TW'(TRC_CYC);
            st_q   <= ST_XWAIT;
          end
        end
        ST_RWAIT, ST_XWAIT: begin
          if (wait_done) st_q <= ST_IDLE;
          else           wcnt_q <= wcnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_rfsh_seq.sv
module sdram_rfsh_seq
  import sdram_rfsh_pkg::*;
#(
  parameter int unsigned      CLK_PS       = 4000,
  parameter int unsigned      TRC_PS       = 60000,
  parameter longint unsigned  REFI_PS      = 64'd15_600_000,
  parameter longint unsigned  BURST_WIN_PS = 64'd32_000_000_000,
  parameter int unsigned      BURST_LEN    = 2048,
  parameter int unsigned      OWED_MAX     = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic burst_mode,
  input  logic banks_idle,
  input  logic ref_gnt,
  output logic ref_req,
  input  logic lp_req,
  output logic lp_ack,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic cke
);
  localparam int unsigned TRC_CYC   = 32'(ps_to_cycles(64'(TRC_PS), 64'(CLK_PS)));
  localparam int unsigned REFI_CYC  = 32'(ps_to_cycles(REFI_PS, 64'(CLK_PS)));
  localparam int unsigned BURST_CYC = 32'(ps_to_cycles(BURST_WIN_PS, 64'(CLK_PS)));

  logic     tick, hold, owed_nz, take, load_burst, clear;
  pin_cmd_t cmd;

  sdram_rfsh_timer #(.PER_DIST(REFI_CYC), .PER_BURST(BURST_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .burst_sel(burst_mode), .hold(hold), .tick(tick)
  );

  sdram_rfsh_debt #(.OWED_MAX(OWED_MAX), .BURST_LEN(BURST_LEN)) u_debt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .burst_sel(burst_mode), .take(take),
    .load_burst(load_burst), .clear(clear), .owed_nz(owed_nz)
  );

  sdram_rfsh_fsm #(.TRC_CYC(TRC_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .owed_nz(owed_nz), .ref_gnt(ref_gnt),
    .banks_idle(banks_idle), .lp_req(lp_req), .burst_sel(burst_mode),
    .cmd_o(cmd), .cke_o(cke), .ref_req(ref_req), .lp_ack(lp_ack),
    .take(take), .load_burst(load_burst), .clear(clear), .timer_hold(hold)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
endmodule

// File: rtl/sdram_rfsh_seq_chk.sv
module sdram_rfsh_seq_chk #(
  parameter int unsigned CLK_PS = 4000,
  parameter int unsigned TRC_PS = 60000
) (
  input logic clk,
  input logic rst_n,
  input logic banks_idle,
  input logic ref_gnt,
  input logic ref_req,
  input logic lp_req,
  input logic lp_ack,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic cke
);
  localparam int unsigned TRC_CYC = (TRC_PS + CLK_PS - 1) / CLK_PS;
  localparam int SW = $clog2(TRC_CYC + 1);

  logic          is_cmd, is_ref, cke_d, ev;
  logic [SW-1:0] since_q;

  assign is_cmd = !cs_n;
  assign is_ref = !cs_n && !ras_n && !cas_n && we_n && cke;
  assign ev     = is_cmd || (cke && !cke_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= SW'(TRC_CYC);
      cke_d   <= 1'b1;
    end else begin
      cke_d <= cke;
      if (ev)                        since_q <= SW'(1);
      else if (since_q < SW'(TRC_CYC)) since_q <= since_q + 1'b1;
    end
  end

  a_r3_ref_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> ($past(ref_gnt) && $past(banks_idle)));
  a_r3_cke_was_high: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> $past(cke));
  a_r4_cmd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (since_q >= SW'(TRC_CYC)));
  a_r5_req_covers_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> $past(ref_req));
  a_r8_ack_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_ack) |-> (!cs_n && !cke));
  a_r9_sr_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    lp_ack |-> !cke);
  a_r9_sr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_ack && $past(lp_ack)) |-> cs_n);
  a_r10_exit_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lp_ack) |-> (cke && cs_n && !$past(lp_req)));
endmodule

bind sdram_rfsh_seq sdram_rfsh_seq_chk #(.CLK_PS(CLK_PS), .TRC_PS(TRC_PS)) u_chk (
  .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .ref_gnt(ref_gnt),
  .ref_req(ref_req), .lp_req(lp_req), .lp_ack(lp_ack), .cs_n(cs_n),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke)
);

// File: tb/test_sdram_rfsh_seq.sv
`timescale 1ns/1ps
module test_sdram_rfsh_seq;
  // 4 ns clock; tRC 10 ns -> 3 cycles; spread interval 40 cycles;
  // batch window 200 cycles with 4 refreshes; owed count caps at 8
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic burst_mode = 1'b0, banks_idle = 1'b1, ref_gnt = 1'b0, lp_req = 1'b0;
  logic ref_req, lp_ack, cs_n, ras_n, cas_n, we_n, cke;

  int checks = 0, errors = 0;
  int cyc = 0, refs = 0, sres = 0, last_ref = -1, min_gap = 999;

  always #2 clk = ~clk;

  sdram_rfsh_seq #(
    .CLK_PS(4000), .TRC_PS(10000), .REFI_PS(64'd160000),
    .BURST_WIN_PS(64'd800000), .BURST_LEN(4), .OWED_MAX(8)
  ) i_sdram_rfsh_seq (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .banks_idle(banks_idle),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .lp_req(lp_req), .lp_ack(lp_ack),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke)
  );

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always @(negedge clk) begin
    if (rst_n && !cs_n && !ras_n && !cas_n && we_n) begin
      if (cke) begin
        refs++;
        if (last_ref >= 0 && cyc - last_ref < min_gap) min_gap = cyc - last_ref;
        last_ref = cyc;
      end else begin
        sres++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic tick_to(input int n);
    while (cyc < n) step(1);
  endtask

  // {ref_gnt, banks_idle, refresh expected}
  localparam logic [2:0] VEC [4] = '{3'b000, 3'b010, 3'b100, 3'b111};

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0, cr;
    step(3);
    check(cke == 1'b1, "R1 cke", cke, 1);
    check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    check(ref_req == 1'b0, "R1 ref_req", ref_req, 0);
    check(lp_ack == 1'b0, "R1 lp_ack", lp_ack, 0);
    rst_n = 1'b1;

    while (!ref_req && cyc < 60) step(1);
    check(cyc == 40, "R2 first request cycle", cyc, 40);

    for (int v = 0; v < 4; v++) begin
      ref_gnt = VEC[v][2];
      banks_idle = VEC[v][1];
      r0 = refs;
      step(3);
      check(refs - r0 == int'(VEC[v][0]), "R3 grant/idle gating", refs - r0, int'(VEC[v][0]));
      if (!VEC[v][0]) check(ref_req == 1'b1, "R5 request held", ref_req, 1);
    end
    check(ref_req == 1'b0, "R5 request released", ref_req, 0);

    ref_gnt = 1'b0;
    tick_to(160);
    min_gap = 999;
    r0 = refs;
    ref_gnt = 1'b1;
    tick_to(172);
    check(refs - r0 == 3, "R6 deferred refreshes", refs - r0, 3);
    check(min_gap == 3, "R4 back-to-back spacing", min_gap, 3);

    ref_gnt = 1'b0;
    tick_to(680);
    r0 = refs;
    ref_gnt = 1'b1;
    tick_to(712);
    check(refs - r0 == 8, "R6 saturation", refs - r0, 8);

    lp_req = 1'b1;
    step(1);
    check(sres == 1, "R8 entry command", sres, 1);
    check(lp_ack == 1'b1, "R8 ack", lp_ack, 1);
    check(cke == 1'b0, "R8 cke low", cke, 0);
    begin
      bit quiet = 1'b1;
      r0 = refs;
      ref_gnt = 1'b0;
      banks_idle = 1'b0;
      for (int k = 0; k < 15; k++) begin
        if (k == 10) begin ref_gnt = 1'b1; banks_idle = 1'b1; end
        step(1);
        if (cke || !cs_n || !lp_ack) quiet = 1'b0;
      end
      check(quiet, "R9 held in self refresh", quiet, 1);
      check(refs == r0, "R9 no refresh in self refresh", refs - r0, 0);
    end
    lp_req = 1'b0;
    step(1);
    check(cke == 1'b1 && lp_ack == 1'b0, "R10 exit pins", {cke, lp_ack}, 2);
    r0 = refs;
    step(15);
    check(refs == r0, "R11 no batch in spread mode", refs - r0, 0);
    check(ref_req == 1'b0, "R10 request released after wait", ref_req, 0);

    burst_mode = 1'b1;
    lp_req = 1'b1;
    step(3);
    lp_req = 1'b0;
    step(1);
    cr = cyc;
    check(cke == 1'b1, "R10 cke raised", cke, 1);
    min_gap = 999;
    last_ref = -1;
    r0 = refs;
    while (refs == r0 && cyc < cr + 20) step(1);
    check(cyc - cr == 4, "R10 first command delay", cyc - cr, 4);
    tick_to(cr + 20);
    check(refs - r0 == 4, "R11 batch after exit", refs - r0, 4);
    check(min_gap == 3, "R4 batch spacing", min_gap, 3);
    tick_to(cr + 225);
    check(refs - r0 == 8, "R7 periodic batch", refs - r0, 8);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule